// File: doc/BRIEF.md
# Position Output Latch Port

This block connects a free-running position counter to a parallel host bus. A holding register copies the counter word on each clock edge. The copy is skipped while the host holds the freeze input low, or while the counter reports an update in progress. The host therefore always reads a word that is consistent with itself and does not change during the read. The word is kept in plain natural binary; the port does no encoding.

The host can read 16 bits at once or one byte at a time over the upper lane. A lane-order input decides which half of the held word goes to the upper lane and which half goes to the lower lane. Bus drive is modelled as a data vector plus an output-enable flag. That flag is asserted only while the active-low read enable is low and no counter preset is under way. The data pins act as inputs during a preset, so only one side ever drives them.

There is no streaming handshake. The read is a direct parallel access, so the host applies no back-pressure. The holding register simply keeps its word for as long as the freeze input stays low.

Top module: `posport_out`

## Requirements
- R1: On a clock edge where freeze_n_i is 1 and busy_i is 0, the holding register takes pos_i. The new word is visible on data_o after that edge.
- R2: On a clock edge where freeze_n_i is 0, the holding register keeps its value. From the first edge that samples freeze_n_i low, data_o stays constant for a fixed lane order, whatever pos_i does.
- R3: On a clock edge where busy_i is 1, the holding register keeps its value. If freeze_n_i returns high while busy_i is still 1, the transfer waits until the first edge with busy_i at 0.
- R4: With byte_sel_i at 1, data_o[15:8] (the upper lane) carries the held most significant byte and data_o[7:0] carries the held least significant byte. The full word is then the held natural-binary value, unaltered.
- R5: With byte_sel_i at 0, data_o[15:8] carries the held least significant byte and data_o[7:0] carries the held most significant byte.
- R6: data_oe_o is 1 when rd_en_n_i is 0 and preset_n_i is 1. data_oe_o is 0 whenever rd_en_n_i is 1.
- R7: While preset_n_i is 0, data_oe_o is 0 regardless of rd_en_n_i.
- R8: After reset the holding register is zero. data_o then reads 0 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_i | input | 16 | Live position word from the counter |
| busy_i | input | 1 | Counter update in progress; word not valid while 1 |
| freeze_n_i | input | 1 | Low freezes the holding register |
| byte_sel_i | input | 1 | 1: MSB byte on upper lane; 0: LSB byte on upper lane |
| rd_en_n_i | input | 1 | Active-low read enable for the bus drive |
| preset_n_i | input | 1 | Active-low counter preset strobe; bus pins are inputs while low |
| data_o | output | 16 | Held word in lane order |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Two functions collide in the same clock edge: the freeze input is released while the counter is still busy. The bench raises freeze_n_i in a cycle where busy_i is high, then drops busy_i one cycle later with a different counter word. It checks that the held word changes only after the busy edge and takes the value present at that edge. The second collision pairs a low read enable with an active preset strobe. The bench drives both in one cycle and checks that the drive flag stays off.

// File: rtl/posport_pkg.sv
package posport_pkg;
  typedef enum logic {
    LANE_LSB_UP = 1'b0,
    LANE_MSB_UP = 1'b1
  } lane_order_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/posport_gate.sv
module posport_gate (
  input  logic freeze_n_i,
  input  logic busy_i,
  input  logic rd_en_n_i,
  input  logic preset_n_i,
  output logic xfer_ok_o,
  output logic drive_o
);
  // Transfer only when the host is not freezing and the counter is settled.
  always_comb begin
    xfer_ok_o = freeze_n_i & ~busy_i;
  end

  // A preset turns the pins into inputs, so it overrides the read enable.
  always_comb begin
    drive_o = ~rd_en_n_i & preset_n_i;
  end
endmodule

// File: rtl/posport_hold.sv
module posport_hold #(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_ok_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= '0;
    end else if (xfer_ok_i) begin
      held_o <= pos_i;
    end
  end
endmodule

// File: rtl/posport_lanes.sv
module posport_lanes
  import posport_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic             byte_sel_i,
  input  logic [POS_W-1:0] held_i,
  output logic [POS_W-1:0] lanes_o
);
  localparam int unsigned HALF_W = POS_W / 2;

  lane_order_e order;
  always_comb begin
    order = lane_order_e'(byte_sel_i);
  end

  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    always_comb begin
      if (order == LANE_MSB_UP) begin
        lanes_o[HALF_W + b] = held_i[HALF_W + b];
        lanes_o[b]          = held_i[b];
      end else begin
        lanes_o[HALF_W + b] = held_i[b];
        lanes_o[b]          = held_i[HALF_W + b];
      end
    end
  end
endmodule

// File: rtl/posport_out.sv
module posport_out
  import posport_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  logic             busy_i,
  input  logic             freeze_n_i,
  input  logic             byte_sel_i,
  input  logic             rd_en_n_i,
  input  logic             preset_n_i,
  output logic [POS_W-1:0] data_o,
  output logic             data_oe_o
);
  logic             xfer_ok;
  logic [POS_W-1:0] held_q;

  posport_gate u_gate (
    .freeze_n_i (freeze_n_i),
    .busy_i     (busy_i),
    .rd_en_n_i  (rd_en_n_i),
    .preset_n_i (preset_n_i),
    .xfer_ok_o  (xfer_ok),
    .drive_o    (data_oe_o)
  );

  posport_hold #(.POS_W(POS_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_ok_i (xfer_ok),
    .pos_i     (pos_i),
    .held_o    (held_q)
  );

  posport_lanes #(.POS_W(POS_W)) u_lanes (
    .byte_sel_i (byte_sel_i),
    .held_i     (held_q),
    .lanes_o    (data_o)
  );
endmodule

// File: rtl/posport_out_chk.sv
module posport_out_chk #(
  parameter int unsigned POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] pos_i,
  input logic             busy_i,
  input logic             freeze_n_i,
  input logic             byte_sel_i,
  input logic             rd_en_n_i,
  input logic             preset_n_i,
  input logic [POS_W-1:0] data_o,
  input logic             data_oe_o,
  input logic [POS_W-1:0] held_q
);
  localparam int unsigned HALF_W = POS_W / 2;

  AST_XFER_TAKES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_n_i && !busy_i) |=> (held_q == $past(pos_i))); // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_n_i) |=> $stable(held_q)); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(held_q)); // R3
  AST_MSB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sel_i |-> (data_o == held_q)); // R4
  AST_LSB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_sel_i |-> (data_o[POS_W-1:HALF_W] == held_q[HALF_W-1:0])); // R5
  AST_NO_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n_i |-> !data_oe_o); // R6
  AST_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n_i && preset_n_i) |-> data_oe_o); // R6
  AST_NO_DRIVE_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n_i |-> !data_oe_o); // R7
endmodule

bind posport_out posport_out_chk #(.POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pos_i      (pos_i),
  .busy_i     (busy_i),
  .freeze_n_i (freeze_n_i),
  .byte_sel_i (byte_sel_i),
  .rd_en_n_i  (rd_en_n_i),
  .preset_n_i (preset_n_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .held_q     (held_q)
);

// File: tb/posport_out_test.sv
module posport_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pos_i = '0;
  logic        busy_i = 1'b0;
  logic        freeze_n_i = 1'b0;
  logic        byte_sel_i = 1'b1;
  logic        rd_en_n_i = 1'b1;
  logic        preset_n_i = 1'b1;
  logic [15:0] data_o;
  logic        data_oe_o;

  always #5 clk = ~clk;

  posport_out uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_i      (pos_i),
    .busy_i     (busy_i),
    .freeze_n_i (freeze_n_i),
    .byte_sel_i (byte_sel_i),
    .rd_en_n_i  (rd_en_n_i),
    .preset_n_i (preset_n_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  typedef struct {
    logic [15:0] data;
    logic        oe;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          failures = 0;
  logic [15:0] model_held = '0;

  task automatic drive(input logic [15:0] pos, input logic busy, input logic frz_n,
                       input logic sel, input logic en_n, input logic pre_n,
                       input string tag);
    exp_t e;
    @(negedge clk);
    pos_i = pos; busy_i = busy; freeze_n_i = frz_n;
    byte_sel_i = sel; rd_en_n_i = en_n; preset_n_i = pre_n;
    if (frz_n && !busy) model_held = pos;
    e.data = sel ? model_held : {model_held[7:0], model_held[15:8]};
    e.oe   = !en_n && pre_n;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (data_o !== e.data) begin
          failures++;
          $display("FAIL %s data_o actual=%h expected=%h", e.tag, data_o, e.data);
        end
        checks++;
        if (data_oe_o !== e.oe) begin
          failures++;
          $display("FAIL %s data_oe_o actual=%b expected=%b", e.tag, data_oe_o, e.oe);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: frozen right after reset, holding register reads zero
    drive(16'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    drive(16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    // R1 and R4: transfer, MSB byte on the upper lane
    drive(16'hA55A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
    drive(16'hC3F0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
    // R5: lanes swapped
    drive(16'hC3F0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    drive(16'h0180, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    // R2: freeze while the counter keeps moving
    drive(16'h0F0F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
    drive(16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
    drive(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
    // R3: busy blocks, release of freeze during busy waits
    drive(16'h1111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    drive(16'h2222, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
    drive(16'h3333, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    drive(16'h4444, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    // R6: read enable high releases the bus
    drive(16'h5555, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    drive(16'h6666, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
    // R7: preset overrides a low read enable
    drive(16'h7777, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    drive(16'h8888, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    drive(16'h9999, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    // mixed sweep over all controls
    v = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      v = {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
      drive(v, v[0], v[1] | v[2], v[3], v[4] & v[5], v[6] | v[7], "R1");
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule